// File: doc/BRIEF.md
# Serial Adapter Host Register Interface

This block connects a simple microprocessor bus to the control and status registers of a serial adapter. Only the host-facing part is here: the transmit and receive shifters live elsewhere. Those neighbours supply their flags, and this block returns the configuration fields and one-cycle access strobes to them. It decodes a three-bit chip select, a read/not-write line, a register select and an enable strobe. It has separate 8-bit buses for data in and data out.

The enable strobe is asynchronous to the block clock, which is the free-running transmit clock. The strobe is passed through a synchronizer, and its edges are detected in the clock domain. A register write and the side effects of a read take place once per access, when the falling edge of the strobe is seen. Read data is driven as soon as the strobe is high. The block keeps the 8-bit control byte. It builds the status byte from the neighbours' flags and its own state. It latches a carrier-loss event, and it drives the active-low interrupt and request-to-send pins.

Top module: `host_reg_if`

## Requirements
- R1: An access takes effect only when `chipSel` equals 3'b110. With any other code, a write changes no output or register, produces no strobe, and `dataOut` reads 8'h00.
- R2: On a selected write, `regSel`=0 loads the control byte from `dataIn`. `regSel`=1 leaves the control byte untouched and delivers `dataIn` on `txWrData` with one `txWrStb` pulse.
- R3: On a selected read, `regSel`=1 drives `rxData` on `dataOut` and produces one `rxRdStb` pulse. `regSel`=0 drives the status byte on `dataOut`.
- R4: The control byte fields are decoded as follows. Bits 1:0 appear on `divCode`, bits 4:2 on `fmtCode`, bits 6:5 form the transmit control code, and bit 7 is the receive interrupt enable.
- R5: The transmit control code sets the outputs as follows. 00 gives `rtsN` low with no break. 01 gives `rtsN` low. 10 gives `rtsN` high. 11 gives `rtsN` low with `breakOn` high.
- R6: With transmit control code 01, the interrupt is raised (`irqN` low) when `txEmpty` is high and `ctsN` is low. The transmit-empty status bit is forced to 0 while CTS is high.
- R7: With bit 7 of the control byte set, `irqN` goes low when receive-full, overrun or the carrier-loss flag is set. Framing and parity errors alone raise no interrupt.
- R8: The status byte layout, from bit 0 to bit 7, is: receive full, transmit empty, carrier loss, CTS, framing error, overrun, parity error, interrupt request. Bit 7 is the inverse of `irqN`.
- R9: A low-to-high transition of `dcdN` sets the carrier-loss flag. The flag survives status reads until a status read that follows a receive-data read clears it.
- R10: While `rstN` is low, the control byte is 0 and the CTS status bit reads 1 whatever `ctsN` is. After reset, the CTS bit tracks `ctsN`.
- R11: When the control byte bits 1:0 equal 11, `masterReset` is high. While it is high, the receive flags, the transmit-empty bit and the interrupt are masked, and the carrier-loss flag is cleared.
- R12: An access produces exactly one strobe pulse, however long the enable stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running transmit clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chipSel | input | 3 | Chip select code |
| readNotWrite | input | 1 | 1 = read, 0 = write |
| regSel | input | 1 | Register select |
| busEn | input | 1 | Asynchronous access enable strobe |
| dataIn | input | 8 | Write data from host |
| dataOut | output | 8 | Read data to host |
| rxData | input | 8 | Receive data register contents |
| rxFull | input | 1 | Receive register full flag |
| txEmpty | input | 1 | Transmit register empty flag |
| frameErr | input | 1 | Framing error flag |
| overrun | input | 1 | Overrun flag |
| parityErr | input | 1 | Parity error flag |
| ctsN | input | 1 | Clear to send, active low |
| dcdN | input | 1 | Carrier detect, active low |
| irqN | output | 1 | Interrupt request, active low |
| rtsN | output | 1 | Request to send, active low |
| divCode | output | 2 | Clock divide code to shifters |
| fmtCode | output | 3 | Word format code to shifters |
| breakOn | output | 1 | Send break on transmit line |
| masterReset | output | 1 | Synchronous reset request to shifters |
| txWrStb | output | 1 | One-cycle transmit data write pulse |
| txWrData | output | 8 | Transmit data captured on write |
| rxRdStb | output | 1 | One-cycle receive data read pulse |

## Verification
The bench builds the block with its default parameters: a two-flop synchronizer on the enable strobe and a select match code of 3'b110. These values let the bench hold the enable for several clocks, so the single-pulse property is tested against a long access. The bench also drives the non-matching select codes 3'b010 and 3'b111 to show that an unselected access is ignored. The two-flop latency sets the wait after each access edge, and the carrier-detect path adds two stages of its own before the flag changes.

// File: rtl/hri_pkg.sv
package hri_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic ctrlWr;
    logic txWr;
    logic statRd;
    logic rxRd;
  } hostStb_t;

  localparam logic [1:0] TC_RTS_OFF = 2'b10;
  localparam logic [1:0] TC_TX_IRQ  = 2'b01;
  localparam logic [1:0] TC_BREAK   = 2'b11;
  localparam logic [1:0] DIV_MRESET = 2'b11;
endpackage

// File: rtl/hri_busctl.sv
module hri_busctl
  import hri_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [2:0] CS_MATCH    = 3'b110
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic [2:0] chipSel,
  input  logic     readNotWrite,
  input  logic     regSel,
  input  logic     busEn,
  output hostStb_t stb
);
  logic [SYNC_STAGES-1:0] enSync;
  logic enPrev, enRise, enFall;
  logic selHit, isRead, selReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enSync <= '0;
      enPrev <= 1'b0;
    end else begin
      enSync <= {enSync[SYNC_STAGES-2:0], busEn};
      enPrev <= enSync[SYNC_STAGES-1];
    end
  end

  assign enRise = enSync[SYNC_STAGES-1] & ~enPrev;
  assign enFall = ~enSync[SYNC_STAGES-1] & enPrev;

  // access attributes are captured when the strobe rise is seen
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selHit <= 1'b0;
      isRead <= 1'b0;
      selReg <= 1'b0;
    end else if (enRise) begin
      selHit <= (chipSel == CS_MATCH);
      isRead <= readNotWrite;
      selReg <= regSel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stb <= '0;
    end else begin
      stb        <= '0;
      stb.ctrlWr <= enFall & selHit & ~isRead & ~selReg;
      stb.txWr   <= enFall & selHit & ~isRead &  selReg;
      stb.statRd <= enFall & selHit &  isRead & ~selReg;
      stb.rxRd   <= enFall & selHit &  isRead &  selReg;
    end
  end
endmodule

// File: rtl/hri_regs.sv
module hri_regs
  import hri_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  hostStb_t          stb,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              rxFull,
  input  logic              txEmpty,
  input  logic              frameErr,
  input  logic              overrun,
  input  logic              parityErr,
  input  logic              ctsN,
  input  logic              dcdN,
  output logic [DATA_W-1:0] statusByte,
  output logic              irqN,
  output logic              rtsN,
  output logic [1:0]        divCode,
  output logic [2:0]        fmtCode,
  output logic              breakOn,
  output logic              masterReset,
  output logic              txWrStb,
  output logic [DATA_W-1:0] txWrData,
  output logic              carrierFlag
);
  logic [DATA_W-1:0] ctrlByte;
  logic [1:0] txCtl;
  logic rxIrqEn, ctsReg;
  logic dcdS1, dcdS2, dcdPrev, dcdRise, rdArmed;
  logic rxFullM, ovrM, feM, peM, tdreBit, irq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlByte <= '0;
    else if (stb.ctrlWr) ctrlByte <= dataIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txWrStb  <= 1'b0;
      txWrData <= '0;
    end else begin
      txWrStb <= stb.txWr;
      if (stb.txWr) txWrData <= dataIn;
    end
  end

  assign divCode     = ctrlByte[1:0];
  assign fmtCode     = ctrlByte[4:2];
  assign txCtl       = ctrlByte[6:5];
  assign rxIrqEn     = ctrlByte[7];
  assign masterReset = (divCode == DIV_MRESET);
  assign rtsN        = (txCtl == TC_RTS_OFF);
  assign breakOn     = (txCtl == TC_BREAK);

  // CTS bit comes out of reset high and follows the pin from the first edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctsReg <= 1'b1;
    else       ctsReg <= ctsN;
  end

  // carrier detect: synchronize, catch the rising edge, hold until read sequence
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dcdS1   <= 1'b1;
      dcdS2   <= 1'b1;
      dcdPrev <= 1'b1;
    end else begin
      dcdS1   <= dcdN;
      dcdS2   <= dcdS1;
      dcdPrev <= dcdS2;
    end
  end
  assign dcdRise = dcdS2 & ~dcdPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdArmed     <= 1'b0;
      carrierFlag <= 1'b0;
    end else if (masterReset) begin
      rdArmed     <= 1'b0;
      carrierFlag <= 1'b0;
    end else begin
      if (stb.rxRd) rdArmed <= 1'b1;
      else if (stb.statRd) rdArmed <= 1'b0;
      if (dcdRise) carrierFlag <= 1'b1;
      else if (stb.statRd && rdArmed) carrierFlag <= 1'b0;
    end
  end

  assign rxFullM = rxFull    & ~masterReset;
  assign ovrM    = overrun   & ~masterReset;
  assign feM     = frameErr  & ~masterReset;
  assign peM     = parityErr & ~masterReset;
  assign tdreBit = txEmpty & ~ctsReg & ~masterReset;

  assign irq  = ((txCtl == TC_TX_IRQ) & tdreBit) |
                (rxIrqEn & (rxFullM | ovrM | carrierFlag));
  assign irqN = ~irq;

  assign statusByte = {irq, peM, ovrM, feM, ctsReg, carrierFlag, tdreBit, rxFullM};
endmodule

// File: rtl/host_reg_if.sv
module host_reg_if
  import hri_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [2:0] CS_MATCH    = 3'b110
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] chipSel,
  input  logic       readNotWrite,
  input  logic       regSel,
  input  logic       busEn,
  input  logic [7:0] dataIn,
  output logic [7:0] dataOut,
  input  logic [7:0] rxData,
  input  logic       rxFull,
  input  logic       txEmpty,
  input  logic       frameErr,
  input  logic       overrun,
  input  logic       parityErr,
  input  logic       ctsN,
  input  logic       dcdN,
  output logic       irqN,
  output logic       rtsN,
  output logic [1:0] divCode,
  output logic [2:0] fmtCode,
  output logic       breakOn,
  output logic       masterReset,
  output logic       txWrStb,
  output logic [7:0] txWrData,
  output logic       rxRdStb
);
  hostStb_t stb;
  logic [DATA_W-1:0] statusByte;
  logic carrierFlag, rdActive;

  hri_busctl #(.SYNC_STAGES(SYNC_STAGES), .CS_MATCH(CS_MATCH)) u_busctl (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .readNotWrite(readNotWrite),
    .regSel(regSel), .busEn(busEn), .stb(stb)
  );

  hri_regs u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .dataIn(dataIn),
    .rxFull(rxFull), .txEmpty(txEmpty), .frameErr(frameErr), .overrun(overrun),
    .parityErr(parityErr), .ctsN(ctsN), .dcdN(dcdN), .statusByte(statusByte),
    .irqN(irqN), .rtsN(rtsN), .divCode(divCode), .fmtCode(fmtCode),
    .breakOn(breakOn), .masterReset(masterReset), .txWrStb(txWrStb),
    .txWrData(txWrData), .carrierFlag(carrierFlag)
  );

  assign rxRdStb  = stb.rxRd;
  assign rdActive = (chipSel == CS_MATCH) & readNotWrite & busEn;
  assign dataOut  = rdActive ? (regSel ? rxData : statusByte) : '0;
endmodule

// File: rtl/host_reg_if_chk.sv
module host_reg_if_chk
  import hri_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input hostStb_t   stb,
  input logic       txWrStb,
  input logic       rxRdStb,
  input logic [1:0] divCode,
  input logic [2:0] fmtCode,
  input logic       masterReset,
  input logic       carrierFlag
);
  a_r12_single_tx: assert property (@(posedge clk) disable iff (!rstN)
    txWrStb |=> !txWrStb);
  a_r12_single_rd: assert property (@(posedge clk) disable iff (!rstN)
    rxRdStb |=> !rxRdStb);
  a_r2_strobe_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));
  a_r4_ctrl_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ctrlWr |=> $stable({divCode, fmtCode}));
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (carrierFlag && !stb.statRd && !masterReset) |=> carrierFlag);
  a_r11_mr_clears: assert property (@(posedge clk) disable iff (!rstN)
    masterReset |=> !carrierFlag);
endmodule

bind host_reg_if host_reg_if_chk u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .txWrStb(txWrStb), .rxRdStb(rxRdStb),
  .divCode(divCode), .fmtCode(fmtCode), .masterReset(masterReset),
  .carrierFlag(carrierFlag)
);

// File: tb/host_reg_if_tb.sv
module host_reg_if_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] chipSel = 3'b110;
  logic readNotWrite = 1'b1, regSel = 1'b0, busEn = 1'b1;
  logic [7:0] dataIn = 8'h00, rxData = 8'h00;
  logic rxFull = 0, txEmpty = 1, frameErr = 0, overrun = 0, parityErr = 0;
  logic ctsN = 0, dcdN = 0;
  logic [7:0] dataOut, txWrData;
  logic irqN, rtsN, breakOn, masterReset, txWrStb, rxRdStb;
  logic [1:0] divCode;
  logic [2:0] fmtCode;
  int checks = 0, errors = 0, txCount = 0, rxCount = 0, cycles = 0;

  always #5 clk = ~clk;

  host_reg_if u_dut (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .readNotWrite(readNotWrite),
    .regSel(regSel), .busEn(busEn), .dataIn(dataIn), .dataOut(dataOut),
    .rxData(rxData), .rxFull(rxFull), .txEmpty(txEmpty), .frameErr(frameErr),
    .overrun(overrun), .parityErr(parityErr), .ctsN(ctsN), .dcdN(dcdN),
    .irqN(irqN), .rtsN(rtsN), .divCode(divCode), .fmtCode(fmtCode),
    .breakOn(breakOn), .masterReset(masterReset), .txWrStb(txWrStb),
    .txWrData(txWrData), .rxRdStb(rxRdStb)
  );

  always @(posedge clk) begin
    if (txWrStb) txCount <= txCount + 1;
    if (rxRdStb) rxCount <= rxCount + 1;
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic rs, input logic [7:0] d, input logic [2:0] cs);
    @(negedge clk);
    chipSel = cs; readNotWrite = 1'b0; regSel = rs; dataIn = d;
    repeat (2) @(negedge clk);
    busEn = 1'b1;
    repeat (6) @(negedge clk);
    busEn = 1'b0;
    repeat (6) @(negedge clk);
    chipSel = 3'b110;
  endtask

  task automatic hostRead(input logic rs, input logic [2:0] cs, output logic [7:0] d);
    @(negedge clk);
    chipSel = cs; readNotWrite = 1'b1; regSel = rs;
    repeat (2) @(negedge clk);
    busEn = 1'b1;
    repeat (6) @(negedge clk);
    d = dataOut;
    busEn = 1'b0;
    repeat (6) @(negedge clk);
    chipSel = 3'b110;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic testReset();
    logic [7:0] d;
    repeat (2) @(negedge clk);
    check("R10 cts bit high in reset", dataOut, 8'h08);
    check("R10 control zero in reset", {divCode, fmtCode, rtsN, breakOn}, 8'h00);
    busEn = 1'b0;
    @(negedge clk); rstN = 1'b1;
    settle();
    hostRead(1'b0, 3'b110, d);
    check("R10 R8 status after reset", d, 8'h02);
    txEmpty = 1'b0;
  endtask

  task automatic testSelect();
    logic [7:0] d;
    hostWrite(1'b0, 8'hE7, 3'b010);
    check("R1 unselected control write", {divCode, fmtCode, breakOn}, 8'h00);
    hostWrite(1'b1, 8'h3C, 3'b111);
    check("R1 unselected tx write no strobe", 8'(txCount), 8'd0);
    hostRead(1'b0, 3'b111, d);
    check("R1 unselected read", d, 8'h00);
  endtask

  task automatic testWrites();
    logic [7:0] d;
    hostWrite(1'b0, 8'h15, 3'b110);
    check("R4 divCode", {6'd0, divCode}, 8'h01);
    check("R4 fmtCode", {5'd0, fmtCode}, 8'h05);
    hostWrite(1'b1, 8'hA7, 3'b110);
    check("R2 R12 one tx strobe", 8'(txCount), 8'd1);
    check("R2 tx data", txWrData, 8'hA7);
    check("R2 control untouched", {6'd0, divCode}, 8'h01);
    rxData = 8'h5C;
    hostRead(1'b1, 3'b110, d);
    check("R3 rx data read", d, 8'h5C);
    check("R3 R12 one rx strobe", 8'(rxCount), 8'd1);
  endtask

  task automatic testRts();
    hostWrite(1'b0, 8'h40, 3'b110);
    check("R5 code 10", {6'd0, rtsN, breakOn}, 8'h02);
    hostWrite(1'b0, 8'h60, 3'b110);
    check("R5 code 11", {6'd0, rtsN, breakOn}, 8'h01);
    hostWrite(1'b0, 8'h20, 3'b110);
    check("R5 code 01", {6'd0, rtsN, breakOn}, 8'h00);
  endtask

  task automatic testTxIrq();
    logic [7:0] d;
    txEmpty = 1'b1; ctsN = 1'b0;
    settle();
    check("R6 tx irq", {7'd0, irqN}, 8'h00);
    hostRead(1'b0, 3'b110, d);
    check("R6 R8 status tx irq", d, 8'h82);
    ctsN = 1'b1;
    settle();
    check("R6 cts blocks irq", {7'd0, irqN}, 8'h01);
    hostRead(1'b0, 3'b110, d);
    check("R6 tdre masked by cts", d, 8'h08);
    ctsN = 1'b0;
    hostWrite(1'b0, 8'h00, 3'b110);
    check("R6 irq off code 00", {7'd0, irqN}, 8'h01);
    txEmpty = 1'b0;
  endtask

  task automatic testRxIrq();
    logic [7:0] d;
    hostWrite(1'b0, 8'h80, 3'b110);
    rxFull = 1'b1;
    settle();
    check("R7 rx full irq", {7'd0, irqN}, 8'h00);
    hostRead(1'b0, 3'b110, d);
    check("R7 R8 status rx full", d, 8'h81);
    rxFull = 1'b0; overrun = 1'b1;
    settle();
    check("R7 overrun irq", {7'd0, irqN}, 8'h00);
    hostRead(1'b0, 3'b110, d);
    check("R8 status overrun", d, 8'hA0);
    overrun = 1'b0; frameErr = 1'b1; parityErr = 1'b1;
    settle();
    check("R7 errors no irq", {7'd0, irqN}, 8'h01);
    hostRead(1'b0, 3'b110, d);
    check("R8 status fe pe", d, 8'h50);
    frameErr = 1'b0; parityErr = 1'b0;
    hostWrite(1'b0, 8'h00, 3'b110);
  endtask

  task automatic testCarrier();
    logic [7:0] d;
    dcdN = 1'b1;
    settle();
    hostRead(1'b0, 3'b110, d);
    check("R9 carrier set", d, 8'h04);
    dcdN = 1'b0;
    settle();
    hostRead(1'b0, 3'b110, d);
    check("R9 carrier sticky", d, 8'h04);
    hostWrite(1'b0, 8'h80, 3'b110);
    check("R7 carrier irq", {7'd0, irqN}, 8'h00);
    hostWrite(1'b0, 8'h00, 3'b110);
    hostRead(1'b1, 3'b110, d);
    hostRead(1'b0, 3'b110, d);
    check("R9 clearing read sees flag", d, 8'h04);
    hostRead(1'b0, 3'b110, d);
    check("R9 carrier cleared", d, 8'h00);
  endtask

  task automatic testMasterReset();
    logic [7:0] d;
    dcdN = 1'b1; rxFull = 1'b1;
    settle();
    hostWrite(1'b0, 8'h83, 3'b110);
    check("R11 master reset out", {7'd0, masterReset}, 8'h01);
    check("R11 irq masked", {7'd0, irqN}, 8'h01);
    hostRead(1'b0, 3'b110, d);
    check("R11 status masked", d, 8'h00);
    hostWrite(1'b0, 8'h00, 3'b110);
    hostRead(1'b0, 3'b110, d);
    check("R11 carrier cleared by master reset", d, 8'h01);
    rxFull = 1'b0;
  endtask

  initial begin
    testReset();
    testSelect();
    testWrites();
    testRts();
    testTxIrq();
    testRxIrq();
    testCarrier();
    testMasterReset();
    check("R12 total tx strobes", 8'(txCount), 8'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule